// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block drives the digital side of a dual-slope analog-to-digital converter. When a start strobe arrives while the block is idle, it closes the input switch for a fixed number of clock cycles so that the integrator charges. It then opens that switch and closes the reference switch, which discharges the integrator with a current of opposite polarity. During this de-integrate phase the block counts cycles in decimal until the external comparator reports that the integrator has returned to its starting level.

The count is kept directly as three BCD digits. When the cycle ends, the block latches the count together with a sign bit, which is the polarity flag captured at the start strobe. Positive readings run up to 999. Negative readings run down to -99. Beyond those limits the block reports a separate positive or negative overrange flag and forces the digits to zero. If the comparator never trips, a watchdog on the de-integrate length aborts the cycle and reports overrange. A one-cycle done pulse marks the moment the latched result changes.

Top module: `dsc_sequencer`

## Requirements
- R1: While reset is asserted and after its release, both switch controls, busy and done are low, and the digits, sign and both overrange flags are zero.
- R2: A start strobe sampled while idle raises the input switch in the next cycle and holds it for exactly INT_TICKS cycles. A start strobe sampled while busy does nothing.
- R3: When the input switch drops, the reference switch rises in the same cycle. The two switches are never high together.
- R4: The reading is the number of de-integrate cycles in which the comparator input was high before the first cycle in which it was low. Digits are packed as hundreds in bits 11:8, tens in bits 7:4 and units in bits 3:0.
- R5: The sign output equals the polarity flag sampled with the accepted start strobe, where 1 means negative.
- R6: With positive polarity, a count of 1000 or more sets the positive overrange flag and zeroes the digits.
- R7: With negative polarity, a count of 100 or more sets the negative overrange flag and zeroes the digits.
- R8: If the comparator is still high in de-integrate cycle number MAX_DEINT, the cycle ends there with the overrange flag of the captured polarity set.
- R9: Done is a single-cycle pulse in the cycle after the conversion ends. The digits, sign and flags change only in that cycle. Busy is high exactly while one of the switches is closed.
- R10: The two overrange flags are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion start strobe |
| cmp_hi | input | 1 | Comparator level; high while the integrator has not returned to its start level |
| neg_pol | input | 1 | Input polarity, 1 = negative, sampled with start |
| in_sw | output | 1 | Input path switch control (integrate phase) |
| ref_sw | output | 1 | Reference path switch control (de-integrate phase) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result updates |
| rd_digits | output | 12 | Latched BCD reading, hundreds/tens/units |
| rd_sign | output | 1 | Latched sign, 1 = negative |
| rd_ovr_pos | output | 1 | Latched positive overrange |
| rd_ovr_neg | output | 1 | Latched negative overrange |

## Verification
The bench builds the block with INT_TICKS = 8 and MAX_DEINT = 1050. The short integrate phase keeps every conversion brief. Because the abort limit sits just above 1000, the bench can reach both ways of getting a positive overrange: a count of 1000 that trips the comparator before the abort, and a comparator that never trips and is cut off at exactly 1050 cycles. Negative readings at 99 and 100 exercise the boundary of the tens carry. A start strobe issued in the middle of a conversion shows that a second request is ignored.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int NDIG = 3;
    localparam int DIGW = 4;

    typedef logic [DIGW-1:0] bcd_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INTEG = 2'd1,
        PH_DEINT = 2'd2
    } phase_t;

    typedef struct packed {
        logic                 sign;
        logic                 ovr_pos;
        logic                 ovr_neg;
        logic [NDIG*DIGW-1:0] digits;
    } reading_t;

    function automatic logic is_nine(bcd_t d);
        return d == bcd_t'(9);
    endfunction

    function automatic bcd_t bcd_step(bcd_t d);
        return is_nine(d) ? bcd_t'(0) : d + bcd_t'(1);
    endfunction

endpackage

// File: rtl/dsc_tick_timer.sv
module dsc_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter
    import dsc_pkg::*;
#(
    parameter int ND  = NDIG,
    localparam int SW = (ND > 1) ? $clog2(ND) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               inc,
    input  logic [SW-1:0]      top_dig,
    output logic [ND*DIGW-1:0] digits,
    output logic               ovf
);

    logic [ND:0]   en_chain;
    logic [ND-1:0] carry;

    assign en_chain[0] = inc;

    for (genvar i = 0; i < ND; i++) begin : g_stage
        bcd_t d_q;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                d_q <= '0;
            end else if (en_chain[i]) begin
                d_q <= bcd_step(d_q);
            end
        end

        assign carry[i]         = en_chain[i] && is_nine(d_q);
        assign en_chain[i+1]    = carry[i];
        assign digits[i*DIGW +: DIGW] = d_q;
    end

    assign ovf = carry[top_dig];

endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
    import dsc_pkg::*;
#(
    parameter int INT_TICKS = 1000,
    parameter int MAX_DEINT = 2000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 cmp_hi,
    input  logic                 neg_pol,
    output logic                 in_sw,
    output logic                 ref_sw,
    output logic                 busy,
    output logic                 done,
    output logic [NDIG*DIGW-1:0] rd_digits,
    output logic                 rd_sign,
    output logic                 rd_ovr_pos,
    output logic                 rd_ovr_neg
);

    localparam int LIM = (INT_TICKS > MAX_DEINT) ? INT_TICKS : MAX_DEINT;
    localparam int TW  = $clog2(LIM + 1);
    localparam int SW  = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam logic [TW-1:0] INT_LAST = TW'(INT_TICKS - 1);
    localparam logic [TW-1:0] DEI_LAST = TW'(MAX_DEINT - 1);
    localparam logic [SW-1:0] NEG_TOP  = SW'(1);
    localparam logic [SW-1:0] POS_TOP  = SW'(NDIG - 1);

    phase_t               state_q;
    logic                 pol_q;
    logic                 ovr_q;
    reading_t             res_q;
    logic                 done_q;
    logic [TW-1:0]        tmr;
    logic [NDIG*DIGW-1:0] cnt_digits;
    logic                 cnt_ovf;

    logic int_last, finish, fin_ovr, tmr_clr, cnt_clr, cnt_inc;

    always_comb begin
        int_last = (state_q == PH_INTEG) && (tmr == INT_LAST);
        tmr_clr  = (state_q == PH_IDLE) || int_last;
        cnt_clr  = (state_q != PH_DEINT);
        cnt_inc  = (state_q == PH_DEINT) && cmp_hi;
        finish   = (state_q == PH_DEINT) && (!cmp_hi || (tmr == DEI_LAST));
        fin_ovr  = cmp_hi ? 1'b1 : ovr_q;
    end

    dsc_tick_timer #(.W(TW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .en  (!tmr_clr),
        .cnt (tmr)
    );

    dsc_bcd_counter #(.ND(NDIG)) u_count (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .top_dig (pol_q ? NEG_TOP : POS_TOP),
        .digits  (cnt_digits),
        .ovf     (cnt_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            pol_q   <= 1'b0;
            ovr_q   <= 1'b0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                PH_IDLE: begin
                    if (start) begin
                        state_q <= PH_INTEG;
                        pol_q   <= neg_pol;
                    end
                end
                PH_INTEG: begin
                    ovr_q <= 1'b0;
                    if (int_last) state_q <= PH_DEINT;
                end
                PH_DEINT: begin
                    if (cnt_ovf) ovr_q <= 1'b1;
                    if (finish) begin
                        state_q       <= PH_IDLE;
                        done_q        <= 1'b1;
                        res_q.sign    <= pol_q;
                        res_q.ovr_pos <= fin_ovr && !pol_q;
                        res_q.ovr_neg <= fin_ovr && pol_q;
                        res_q.digits  <= fin_ovr ? '0 : cnt_digits;
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    assign in_sw      = (state_q == PH_INTEG);
    assign ref_sw     = (state_q == PH_DEINT);
    assign busy       = (state_q != PH_IDLE);
    assign done       = done_q;
    assign rd_digits  = res_q.digits;
    assign rd_sign    = res_q.sign;
    assign rd_ovr_pos = res_q.ovr_pos;
    assign rd_ovr_neg = res_q.ovr_neg;

endmodule

// File: rtl/dsc_sequencer_chk.sv
module dsc_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        in_sw,
    input logic        ref_sw,
    input logic        busy,
    input logic        done,
    input logic [11:0] rd_digits,
    input logic        rd_sign,
    input logic        rd_ovr_pos,
    input logic        rd_ovr_neg
);

    // R3
    switch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_sw && ref_sw));

    // R3
    phase_handover_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(in_sw) |-> ref_sw);

    // R2
    integ_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sw) |-> ($past(start) && !$past(busy)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({rd_digits, rd_sign, rd_ovr_pos, rd_ovr_neg}));

    // R10
    ovr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_ovr_pos && rd_ovr_neg));

    // R6
    ovr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (rd_ovr_pos || rd_ovr_neg)) |-> (rd_digits == 12'h000));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ref_sw));

endmodule

bind dsc_sequencer dsc_sequencer_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_sw      (in_sw),
    .ref_sw     (ref_sw),
    .busy       (busy),
    .done       (done),
    .rd_digits  (rd_digits),
    .rd_sign    (rd_sign),
    .rd_ovr_pos (rd_ovr_pos),
    .rd_ovr_neg (rd_ovr_neg)
);

// File: tb/dsc_sequencer_tb_top.sv
`timescale 1ns/1ps
module dsc_sequencer_tb_top;

    localparam int INT_T = 8;
    localparam int MAX_D = 1050;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cmp_hi = 1'b1;
    logic        neg_pol = 1'b0;
    logic        in_sw, ref_sw, busy, done;
    logic [11:0] rd_digits;
    logic        rd_sign, rd_ovr_pos, rd_ovr_neg;

    int checks = 0;
    int failures = 0;
    int trip_n = 0;
    int k = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dsc_sequencer #(.INT_TICKS(INT_T), .MAX_DEINT(MAX_D)) dut_i (
        .clk(clk), .rst(rst), .start(start), .cmp_hi(cmp_hi), .neg_pol(neg_pol),
        .in_sw(in_sw), .ref_sw(ref_sw), .busy(busy), .done(done),
        .rd_digits(rd_digits), .rd_sign(rd_sign),
        .rd_ovr_pos(rd_ovr_pos), .rd_ovr_neg(rd_ovr_neg)
    );

    function automatic logic [11:0] to_bcd(int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    // Comparator model: high for trip_n de-integrate cycles, then low
    always @(negedge clk) begin
        if (ref_sw) k = k + 1; else k = 0;
        cmp_hi = !ref_sw || (k <= trip_n);
    end

    // Behavioural reference model
    int m_state = 0, m_t = 0, m_cnt = 0;
    bit m_pol = 0;
    bit e_done = 0, e_sign = 0, e_ovp = 0, e_ovn = 0;
    logic [11:0] e_dig = '0;

    task automatic m_finish(bit force_ovr);
        bit o;
        o = force_ovr || (m_pol ? (m_cnt >= 100) : (m_cnt >= 1000));
        e_done = 1; e_sign = m_pol;
        e_ovp = o && !m_pol; e_ovn = o && m_pol;
        e_dig = o ? 12'h000 : to_bcd(m_cnt);
        m_state = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_t = 0; m_cnt = 0; m_pol = 0;
            e_done = 0; e_sign = 0; e_ovp = 0; e_ovn = 0; e_dig = '0;
        end else begin
            e_done = 0;
            case (m_state)
                0: if (start) begin m_state = 1; m_t = 0; m_pol = neg_pol; end
                1: if (m_t == INT_T - 1) begin m_state = 2; m_t = 0; m_cnt = 0; end
                   else m_t++;
                default: begin
                    if (!cmp_hi) m_finish(0);
                    else begin
                        m_cnt++;
                        if (m_t + 1 == MAX_D) m_finish(1);
                        else m_t++;
                    end
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R2 in_sw", in_sw, m_state == 1);
            check("R3 ref_sw", ref_sw, m_state == 2);
            check("R9 busy", busy, m_state != 0);
            check("R9 done", done, e_done);
            check("R4 digits", rd_digits, e_dig);
            check("R5 sign", rd_sign, e_sign);
            check("R6 ovr_pos", rd_ovr_pos, e_ovp);
            check("R7 ovr_neg", rd_ovr_neg, e_ovn);
        end
    end

    task automatic convert(string req, bit pol, int n, bit mid_start,
                           int exp_dig, bit exp_p, bit exp_n, int exp_busy);
        int bc = 0;
        trip_n = n;
        @(negedge clk); start = 1; neg_pol = pol;
        @(negedge clk); start = 0;
        while (busy) begin
            bc++;
            if (mid_start && bc == 3) begin start = 1; neg_pol = !pol; end
            if (mid_start && bc == 4) start = 0;
            @(negedge clk);
        end
        check({req, " done"}, done, 1);
        check({req, " digits"}, rd_digits, exp_dig);
        check({req, " sign"}, rd_sign, pol);
        check({req, " ovr_pos"}, rd_ovr_pos, exp_p);
        check({req, " ovr_neg"}, rd_ovr_neg, exp_n);
        check({req, " busy_len"}, bc, exp_busy);
        @(negedge clk);
        check({req, " done_drop"}, done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 in_sw", in_sw, 0);
        check("R1 ref_sw", ref_sw, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 result", {rd_digits, rd_sign, rd_ovr_pos, rd_ovr_neg}, 0);
        rst = 0;
        @(negedge clk);
        check("R1 after_release", {busy, done, rd_digits}, 0);

        convert("R4 zero",      0, 0,    0, 12'h000, 0, 0, INT_T + 1);
        convert("R4 mid",       0, 537,  0, 12'h537, 0, 0, INT_T + 538);
        convert("R4 max",       0, 999,  0, 12'h999, 0, 0, INT_T + 1000);
        convert("R6 carry",     0, 1000, 0, 12'h000, 1, 0, INT_T + 1001);
        convert("R5 neg",       1, 42,   0, 12'h042, 0, 0, INT_T + 43);
        convert("R7 neg_edge",  1, 99,   0, 12'h099, 0, 0, INT_T + 100);
        convert("R7 neg_ovr",   1, 100,  0, 12'h000, 0, 1, INT_T + 101);
        convert("R8 abort_pos", 0, 5000, 0, 12'h000, 1, 0, INT_T + MAX_D);
        convert("R8 abort_neg", 1, 5000, 0, 12'h000, 0, 1, INT_T + MAX_D);
        convert("R2 busy_start",0, 321,  1, 12'h321, 0, 0, INT_T + 322);
        convert("R10 recover",  0, 7,    0, 12'h007, 0, 0, INT_T + 8);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule